// File: doc/BRIEF.md
# Transmit FIFO with Watermark Requests

This block sits between a bus-side write port and a serial shift engine and holds the words waiting to go out. It is eight words deep by default. A data-request output tells a DMA channel or a processor when to write more words. The fill level at which the request turns on is picked by a small code, in quarter-depth steps.

A second, urgent watermark drives a flag with hysteresis. The flag turns on when the FIFO drains to one level and stays on until it refills to a separate, programmable level. The moment it turns on, a one-cycle interrupt pulse is raised.

When the engine asks for a word and the FIFO is empty, the block still hands over a word. By configuration this is either the last word it sent or all zeros, and the event is recorded in a sticky status bit. Writes that arrive while the FIFO is full are dropped and recorded in a sticky overflow bit. One clear input resets both sticky bits.

Top module: `txq_wm`

## Requirements
- R1: During and straight after reset the FIFO is empty. `urgentFlag`, `urgentIrq`, `underrunErr` and `overflowErr` are 0, and `dataReq` follows `reqCode` for an empty FIFO.
- R2: Words accepted on `wrData` while `wrEn` is high leave on `txWord` in the order they were written. A word is taken from the FIFO in each cycle where `popReq` is high and the FIFO is not empty. `txWord` shows the head word in the same cycle, and a write and a pop in the same cycle both take effect.
- R3: A write while the FIFO holds DEPTH words is dropped. The stored words and their order are unchanged, and `overflowErr` is 1 from the next cycle on. Occupancy never exceeds DEPTH.
- R4: `dataReq` is combinational on the current fill level, with Q = DEPTH/4 and E = free entries. The `reqCode` values are: 0 never; 1 when the FIFO is not full; 2 when E >= Q; 3 when E >= 2Q; 4 when E >= 3Q; 5 when the FIFO is empty. Codes 6 and 7 behave as 0.
- R5: While `urgentFlag` is 0, it becomes 1 in the next cycle if the set condition chosen by `urgSetCode` holds. The codes are: 0 never; 1 when E >= Q; 2 when E >= 2Q; 3 when E >= 3Q; 4 when E = DEPTH. Codes 5 to 7 behave as 0.
- R6: While `urgentFlag` is 1, it becomes 0 in the next cycle only if E <= k*Q, where k is `regClrCode` (0 to 3). Code 0 therefore means "full". Otherwise the flag holds, whatever the set condition says.
- R7: `urgentIrq` is high for exactly the one cycle in which `urgentFlag` changes from 0 to 1.
- R8: A pop request on an empty FIFO with `zeroOnUnderrun` = 0 puts the last word that actually left the FIFO on `txWord`. The value is 0 if no word has left yet. The FIFO is unchanged.
- R9: A pop request on an empty FIFO with `zeroOnUnderrun` = 1 puts all zeros on `txWord`.
- R10: A pop request on an empty FIFO sets `underrunErr` from the next cycle on. `clrStatus` clears both `underrunErr` and `overflowErr` in the next cycle. When a new event and a clear arrive in the same cycle, the event wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe from the bus side |
| wrData | input | DATA_W | Word to store |
| popReq | input | 1 | Engine takes a word this cycle |
| clrStatus | input | 1 | Clears both sticky error bits |
| reqCode | input | 3 | Data-request threshold code |
| urgSetCode | input | 3 | Urgent-flag set threshold code |
| regClrCode | input | 2 | Urgent-flag clear threshold code |
| zeroOnUnderrun | input | 1 | 1: send zeros on underrun, 0: repeat last word |
| txWord | output | DATA_W | Word handed to the engine |
| dataReq | output | 1 | Request for more data |
| urgentFlag | output | 1 | Urgent watermark flag |
| urgentIrq | output | 1 | One-cycle pulse when the flag turns on |
| underrunErr | output | 1 | Sticky underrun status |
| overflowErr | output | 1 | Sticky overflow status |

## Verification
Every threshold code is swept at several fill levels, including the exact boundary counts of each quartile. An off-by-one compare would raise the request or flag one entry early or late. Set and clear windows that overlap and windows that leave a gap are both run. A flag that fell back to the set condition, instead of waiting for the clear level, would drop early.

Underruns are driven in both policies, both before any word has been sent and after the last word has drained. A design that latched the head slot instead of the word actually sent would replay the wrong value. Writes to a full FIFO, with and without a pop in the same cycle, are also covered, as are a clear that coincides with a new error. A design that let the clear win, or that stored the dropped word, would be caught.

// File: rtl/txq_pkg.sv
package txq_pkg;
  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic push;      // store wrData at the tail
    logic pop;       // advance the head, remember sent word
  } txqStrobe_t;
endpackage

// File: rtl/txq_ctrl.sv
module txq_ctrl
  import txq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic          popReq,
  input  logic          clrStatus,
  input  logic [2:0]    reqCode,
  input  logic [2:0]    urgSetCode,
  input  logic [1:0]    regClrCode,
  output txqStrobe_t    strobe,
  output logic [CW-1:0] fillCount,
  output logic          dataReq,
  output logic          urgentFlag,
  output logic          urgentIrq,
  output logic          underrunErr,
  output logic          overflowErr
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [CW-1:0] QTR_C   = CW'(DEPTH / 4);
  localparam logic [CW-1:0] HALF_C  = CW'(2 * (DEPTH / 4));
  localparam logic [CW-1:0] TQ_C    = CW'(3 * (DEPTH / 4));

  logic [CW-1:0] freeSlots;
  logic isFull, isEmpty, underrunEv, overflowEv, setHit, clrHit;

  assign freeSlots  = DEPTH_C - fillCount;
  assign isFull     = (fillCount == DEPTH_C);
  assign isEmpty    = (fillCount == '0);
  assign strobe.push = wrEn && !isFull;
  assign strobe.pop  = popReq && !isEmpty;
  assign underrunEv = popReq && isEmpty;
  assign overflowEv = wrEn && isFull;

  always_comb begin
    unique case (reqCode)
      3'd1:    dataReq = !isFull;
      3'd2:    dataReq = freeSlots >= QTR_C;
      3'd3:    dataReq = freeSlots >= HALF_C;
      3'd4:    dataReq = freeSlots >= TQ_C;
      3'd5:    dataReq = isEmpty;
      default: dataReq = 1'b0;
    endcase
  end

  always_comb begin
    unique case (urgSetCode)
      3'd1:    setHit = freeSlots >= QTR_C;
      3'd2:    setHit = freeSlots >= HALF_C;
      3'd3:    setHit = freeSlots >= TQ_C;
      3'd4:    setHit = isEmpty;
      default: setHit = 1'b0;
    endcase
  end

  always_comb begin
    unique case (regClrCode)
      2'd0:    clrHit = isFull;
      2'd1:    clrHit = freeSlots <= QTR_C;
      2'd2:    clrHit = freeSlots <= HALF_C;
      default: clrHit = freeSlots <= TQ_C;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillCount   <= '0;
      urgentFlag  <= 1'b0;
      urgentIrq   <= 1'b0;
      underrunErr <= 1'b0;
      overflowErr <= 1'b0;
    end else begin
      unique case ({strobe.push, strobe.pop})
        2'b10:   fillCount <= fillCount + 1'b1;
        2'b01:   fillCount <= fillCount - 1'b1;
        default: fillCount <= fillCount;
      endcase
      urgentIrq <= !urgentFlag && setHit;
      if (!urgentFlag) urgentFlag <= setHit;
      else if (clrHit) urgentFlag <= 1'b0;
      if (underrunEv)     underrunErr <= 1'b1;
      else if (clrStatus) underrunErr <= 1'b0;
      if (overflowEv)     overflowErr <= 1'b1;
      else if (clrStatus) overflowErr <= 1'b0;
    end
  end
endmodule

// File: rtl/txq_data.sv
module txq_data
  import txq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  txqStrobe_t        strobe,
  input  logic [CW-1:0]     fillCount,
  input  logic              zeroOnUnderrun,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] txWord
);
  localparam logic [AW-1:0] LAST_P = AW'(DEPTH - 1);

  logic [DATA_W-1:0] store [DEPTH];
  logic [AW-1:0]     wrPtr, rdPtr;
  logic [DATA_W-1:0] lastSent;

  always_ff @(posedge clk) begin
    if (strobe.push) store[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      lastSent <= '0;
    end else begin
      if (strobe.push) wrPtr <= (wrPtr == LAST_P) ? '0 : wrPtr + 1'b1;
      if (strobe.pop) begin
        rdPtr    <= (rdPtr == LAST_P) ? '0 : rdPtr + 1'b1;
        lastSent <= store[rdPtr];
      end
    end
  end

  always_comb begin
    if (fillCount != '0)    txWord = store[rdPtr];
    else if (zeroOnUnderrun) txWord = '0;
    else                    txWord = lastSent;
  end
endmodule

// File: rtl/txq_wm.sv
module txq_wm
  import txq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              popReq,
  input  logic              clrStatus,
  input  logic [2:0]        reqCode,
  input  logic [2:0]        urgSetCode,
  input  logic [1:0]        regClrCode,
  input  logic              zeroOnUnderrun,
  output logic [DATA_W-1:0] txWord,
  output logic              dataReq,
  output logic              urgentFlag,
  output logic              urgentIrq,
  output logic              underrunErr,
  output logic              overflowErr
);
  localparam int CW = $clog2(DEPTH + 1);

  txqStrobe_t    strobe;
  logic [CW-1:0] fillCount;

  txq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .popReq(popReq),
    .clrStatus(clrStatus), .reqCode(reqCode), .urgSetCode(urgSetCode),
    .regClrCode(regClrCode), .strobe(strobe), .fillCount(fillCount),
    .dataReq(dataReq), .urgentFlag(urgentFlag), .urgentIrq(urgentIrq),
    .underrunErr(underrunErr), .overflowErr(overflowErr)
  );

  txq_data #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .fillCount(fillCount),
    .zeroOnUnderrun(zeroOnUnderrun), .wrData(wrData), .txWord(txWord)
  );
endmodule

// File: rtl/txq_wm_chk.sv
module txq_wm_chk #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              popReq,
  input logic              zeroOnUnderrun,
  input logic [2:0]        reqCode,
  input logic [CW-1:0]     fillCount,
  input logic [DATA_W-1:0] txWord,
  input logic              dataReq,
  input logic              urgentFlag,
  input logic              urgentIrq,
  input logic              underrunErr,
  input logic              overflowErr
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= CW'(DEPTH)); // R3
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && fillCount == CW'(DEPTH)) |=> overflowErr); // R3
  AST_REQ_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (reqCode == 3'd0) |-> !dataReq); // R4
  AST_IRQ_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(urgentFlag) |-> urgentIrq); // R7
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    urgentIrq |=> !urgentIrq); // R7
  AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && fillCount == '0 && zeroOnUnderrun) |-> (txWord == '0)); // R9
  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && fillCount == '0) |=> underrunErr); // R10
endmodule

bind txq_wm txq_wm_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .popReq(popReq),
  .zeroOnUnderrun(zeroOnUnderrun), .reqCode(reqCode), .fillCount(fillCount),
  .txWord(txWord), .dataReq(dataReq), .urgentFlag(urgentFlag),
  .urgentIrq(urgentIrq), .underrunErr(underrunErr), .overflowErr(overflowErr)
);

// File: tb/sim_txq_wm.sv
`timescale 1ns/1ps
module sim_txq_wm;
  localparam int DEPTH = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, popReq = 1'b0, clrStatus = 1'b0, zeroOnUnderrun = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic [2:0] reqCode = 3'd1, urgSetCode = 3'd0;
  logic [1:0] regClrCode = 2'd0;
  logic [DW-1:0] txWord;
  logic dataReq, urgentFlag, urgentIrq, underrunErr, overflowErr;

  int checks = 0, errors = 0;
  bit finished = 0;

  // behavioural reference state
  logic [DW-1:0] mq[$];
  logic [DW-1:0] mLast = '0;
  bit mFlag = 0, mIrq = 0, mUnd = 0, mOvf = 0;
  logic [DW-1:0] nextVal = 16'hA001;

  always #10 clk = ~clk;

  txq_wm #(.DEPTH(DEPTH), .DATA_W(DW)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .popReq(popReq),
    .clrStatus(clrStatus), .reqCode(reqCode), .urgSetCode(urgSetCode),
    .regClrCode(regClrCode), .zeroOnUnderrun(zeroOnUnderrun),
    .txWord(txWord), .dataReq(dataReq), .urgentFlag(urgentFlag),
    .urgentIrq(urgentIrq), .underrunErr(underrunErr), .overflowErr(overflowErr)
  );

  function automatic bit expReq(int code, int cnt);
    int freePct = (DEPTH - cnt) * 100 / DEPTH;
    case (code)
      1: return cnt < DEPTH;
      2: return freePct >= 25;
      3: return freePct >= 50;
      4: return freePct >= 75;
      5: return cnt == 0;
      default: return 0;
    endcase
  endfunction

  function automatic bit expSet(int code, int cnt);
    int freePct = (DEPTH - cnt) * 100 / DEPTH;
    case (code)
      1: return freePct >= 25;
      2: return freePct >= 50;
      3: return freePct >= 75;
      4: return cnt == 0;
      default: return 0;
    endcase
  endfunction

  function automatic bit expClr(int code, int cnt);
    int freePct = (DEPTH - cnt) * 100 / DEPTH;
    return freePct <= code * 25;
  endfunction

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every output to the model, then clock once and advance the model
  task automatic step(bit wr, bit pop, bit clr);
    int cnt;
    bit okPush, okPop, und, sHit, cHit;
    wrEn = wr; popReq = pop; clrStatus = clr;
    if (wr) begin wrData = nextVal; end
    #2;
    cnt = mq.size();
    chk("R4 dataReq", {15'd0, dataReq}, {15'd0, expReq(reqCode, cnt)});
    chk("R5/R6 urgentFlag", {15'd0, urgentFlag}, {15'd0, mFlag});
    chk("R7 urgentIrq", {15'd0, urgentIrq}, {15'd0, mIrq});
    chk("R10 underrunErr", {15'd0, underrunErr}, {15'd0, mUnd});
    chk("R3 overflowErr", {15'd0, overflowErr}, {15'd0, mOvf});
    if (pop) begin
      if (cnt > 0) chk("R2 txWord order", txWord, mq[0]);
      else if (zeroOnUnderrun) chk("R9 txWord zero", txWord, '0);
      else chk("R8 txWord repeat", txWord, mLast);
    end
    @(posedge clk);
    okPush = wr && cnt < DEPTH;
    okPop = pop && cnt > 0;
    und = pop && cnt == 0;
    sHit = expSet(urgSetCode, cnt);
    cHit = expClr(regClrCode, cnt);
    if (okPop) mLast = mq.pop_front();
    if (okPush) begin mq.push_back(wrData); nextVal = nextVal + 16'd1; end
    if (wr && cnt == DEPTH) mOvf = 1; else if (clr) mOvf = 0;
    if (und) mUnd = 1; else if (clr) mUnd = 0;
    mIrq = !mFlag && sHit;
    mFlag = mFlag ? !cHit : sHit;
    @(negedge clk);
  endtask

  task automatic sweepReq();
    for (int c = 0; c < 8; c++) begin
      reqCode = 3'(c);
      step(0, 0, 0);
    end
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    #2;
    chk("R1 reset flag", {15'd0, urgentFlag}, 16'd0);
    chk("R1 reset irq", {15'd0, urgentIrq}, 16'd0);
    chk("R1 reset underrun", {15'd0, underrunErr}, 16'd0);
    chk("R1 reset overflow", {15'd0, overflowErr}, 16'd0);
    chk("R1 reset dataReq", {15'd0, dataReq}, 16'd1);
    @(negedge clk);
    rstN = 1'b1;
    step(0, 0, 0);

    // R8: underrun before any word was sent replays 0
    step(0, 1, 0);
    step(0, 0, 1);

    // R5/R6/R7: flag sets when empty, clears once refilled
    urgSetCode = 3'd2; regClrCode = 2'd1;
    step(0, 0, 0);
    step(0, 0, 0);
    // R4: sweep codes at each fill level, including quartile boundaries
    for (int n = 0; n < DEPTH; n++) begin
      sweepReq();
      step(1, 0, 0);
    end
    sweepReq();
    reqCode = 3'd2;

    // R3: overflow, plain and with a pop in the same cycle
    step(1, 0, 0);
    step(1, 1, 0);
    step(0, 0, 0);
    step(1, 0, 1);
    step(0, 0, 1);

    // R2: drain in order, flag re-arms on the way down
    for (int n = 0; n < DEPTH; n++) step(0, 1, 0);
    // R8: replay last word
    zeroOnUnderrun = 1'b0;
    step(0, 1, 0);
    step(0, 1, 0);
    // R9: zeros
    zeroOnUnderrun = 1'b1;
    step(0, 1, 0);
    // R10: event and clear together, event wins; then clear alone
    step(0, 1, 1);
    step(0, 0, 1);
    step(0, 0, 0);

    // R6: hysteresis windows, gap and overlap
    urgSetCode = 3'd3; regClrCode = 2'd0;
    for (int n = 0; n < DEPTH; n++) step(1, 0, 0);
    for (int n = 0; n < DEPTH; n++) step(0, 1, 0);
    urgSetCode = 3'd1; regClrCode = 2'd3;
    for (int n = 0; n < 5; n++) step(1, 0, 0);
    for (int n = 0; n < 5; n++) step(0, 1, 0);

    // R2: simultaneous push and pop, empty and mid-level
    step(1, 1, 0);
    step(1, 1, 0);
    step(1, 0, 0);
    step(1, 1, 0);

    // mixed traffic
    for (int n = 0; n < 600; n++) begin
      if (n % 37 == 0) begin
        reqCode = 3'($urandom % 8);
        urgSetCode = 3'($urandom % 8);
        regClrCode = 2'($urandom % 4);
        zeroOnUnderrun = 1'($urandom % 2);
      end
      step(1'($urandom % 2), 1'($urandom % 2), ($urandom % 23) == 0);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule